// File: doc/BRIEF.md
# Hamming (72,64) Single-Correct / Double-Detect Codec with Built-In Self-Test

This block protects 64-bit words with an extended Hamming code. It works in one of two directions. In encode mode it turns 64 data bits into a 72-bit codeword. In decode mode it checks a 72-bit codeword, repairs any single flipped bit, and flags a word that holds two flipped bits. The check bits are interleaved with the data bits at the power-of-two positions of the codeword, and the overall parity bit sits at position 0. Both directions exchange their data as nine byte lanes.

A self-test mode replaces the input bytes with built-in vectors so that either the encoder or the decoder can be exercised. For the decoder, the test can use a single-error case or a double-error case. The self-test results are fixed and known in advance, so a host can compare them against the expected values.

Each operation starts with a one-cycle start strobe. The clock edge that samples the strobe also registers the result, and the result stays on the outputs until the next strobe. The codec therefore answers in one clock, which is far inside a microsecond at any practical clock rate.

Top module: `secded_codec`

## Requirements
- R1: Encoder layout: codeword bit 0 holds overall parity, bits 1, 2, 4, 8, 16, 32 and 64 hold check bits, and data bits fill all other positions in ascending order. For example, d0 is at position 3, d26 at position 33 and d63 at position 71.
- R2: The check bit at position 2^k makes the XOR over every position whose index has bit k set equal to zero. Bit 0 makes the XOR over all 72 bits equal to zero.
- R3: Byte lane n sits at bits [8n+7:8n] of `inBytes` and `outBytes`, for n from 0 to 8. The encoder reads its data from lanes 0 to 7. The decoder returns its data on lanes 0 to 7 and drives lane 8 to zero.
- R4: A codeword with no error decodes to its original data, with `secFlag` and `dedFlag` both low.
- R5: A single flipped bit at any position from 1 to 71 is corrected. The output shows `secFlag` high and `dedFlag` low.
- R6: A flip of position 0 alone leaves the data unchanged and raises `secFlag`.
- R7: Two flipped bits raise `dedFlag` and keep `secFlag` low. The data lanes then read all zero.
- R8: If the parity is odd and the syndrome points above position 71, the word is reported as a double error: `dedFlag` is high and the data is zero.
- R9: The clock edge that samples `start` high registers the result and raises `done`. `done` stays high for exactly that one cycle.
- R10: While `start` is low, changes on `inBytes`, `autoTest`, `doubleCase` and `encodeSel` leave `outBytes`, the flags and `done` unchanged.
- R11: The self-test encoder case (`autoTest`=1, `encodeSel`=1) outputs the codeword of the built-in data word `TEST_DATA` whatever `doubleCase` is, with both flags low.
- R12: The self-test decoder single-error case (`autoTest`=1, `encodeSel`=0, `doubleCase`=0) returns `TEST_DATA` with `secFlag` high and `dedFlag` low.
- R13: The self-test decoder double-error case (`autoTest`=1, `encodeSel`=0, `doubleCase`=1) returns all-zero data with `dedFlag` high and `secFlag` low.
- R14: During reset, `outBytes` is zero and `secFlag`, `dedFlag` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe that launches an operation |
| autoTest | input | 1 | 1 selects the built-in vectors instead of `inBytes` |
| doubleCase | input | 1 | Self-test decoder case: 0 for single error, 1 for double error |
| encodeSel | input | 1 | 1 selects the encoder, 0 the decoder |
| inBytes | input | 72 | Nine input byte lanes (data or codeword) |
| outBytes | output | 72 | Nine registered output byte lanes |
| secFlag | output | 1 | A single error was corrected |
| dedFlag | output | 1 | The error cannot be corrected |
| done | output | 1 | Result registered this cycle |

## Verification
The assertions assume that `start` is a clean synchronous level, low throughout reset. They also assume that the mode pins and input lanes are settled whenever `start` is high, and that the self-test flip positions are two distinct positions below 72. The stimulus changes every input only on the falling clock edge and raises `start` for one cycle per operation. It also keeps the injected error patterns to the cases the requirements define: zero, one or two flips, plus one three-flip pattern chosen so that the syndrome lands above position 71.

// File: rtl/secded_pkg.sv
package secded_pkg;

  localparam int DATA_W = 64;
  localparam int CW_W   = 72;
  localparam int SYN_W  = 7;
  localparam int LANE_W = 8;
  localparam int LANES  = CW_W / LANE_W;

  typedef struct packed {
    logic capture;
    logic useVector;
    logic encode;
    logic doubleCase;
  } codecCmd_t;

  function automatic logic isCheckPos(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [CW_W-1:0] placeData(input logic [DATA_W-1:0] d);
    logic [CW_W-1:0] w;
    int j;
    w = '0;
    j = 0;
    for (int p = 0; p < CW_W; p++) begin
      if (!isCheckPos(p)) begin
        w[p] = d[j];
        j++;
      end
    end
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] extractData(input logic [CW_W-1:0] w);
    logic [DATA_W-1:0] d;
    int j;
    d = '0;
    j = 0;
    for (int p = 0; p < CW_W; p++) begin
      if (!isCheckPos(p)) begin
        d[j] = w[p];
        j++;
      end
    end
    return d;
  endfunction

  function automatic logic [SYN_W-1:0] syndromeOf(input logic [CW_W-1:0] w);
    logic [SYN_W-1:0] s;
    s = '0;
    for (int k = 0; k < SYN_W; k++) begin
      for (int p = 1; p < CW_W; p++) begin
        if (((p >> k) & 1) == 1) s[k] = s[k] ^ w[p];
      end
    end
    return s;
  endfunction

  function automatic logic [CW_W-1:0] encodeWord(input logic [DATA_W-1:0] d);
    logic [CW_W-1:0] w;
    logic [SYN_W-1:0] s;
    w = placeData(d);
    s = syndromeOf(w);
    for (int k = 0; k < SYN_W; k++) w[1 << k] = s[k];
    w[0] = ^w[CW_W-1:1];
    return w;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] dataIn,
  output logic [CW_W-1:0]   codeOut
);

  always_comb codeOut = encodeWord(dataIn);

endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic [CW_W-1:0]   codeIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              secHit,
  output logic              dedHit
);

  logic [SYN_W-1:0] syn;
  logic             oddParity;
  logic [CW_W-1:0]  repaired;

  always_comb begin
    syn       = syndromeOf(codeIn);
    oddParity = ^codeIn;
    repaired  = codeIn;
    secHit    = 1'b0;
    dedHit    = 1'b0;
    if (oddParity) begin
      if (syn == '0) begin
        secHit = 1'b1;
      end else if (int'(syn) < CW_W) begin
        repaired[syn] = ~codeIn[syn];
        secHit        = 1'b1;
      end else begin
        dedHit = 1'b1;
      end
    end else if (syn != '0) begin
      dedHit = 1'b1;
    end
    dataOut = dedHit ? '0 : extractData(repaired);
  end

  // R5
  always_comb sec_ded_excl_chk: assert (!(secHit && dedHit));

endmodule

// File: rtl/secded_ctrl.sv
module secded_ctrl
  import secded_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      autoTest,
  input  logic      doubleCase,
  input  logic      encodeSel,
  output codecCmd_t cmd,
  output logic      done
);

  logic doneQ;

  always_comb begin
    cmd.capture    = start;
    cmd.useVector  = start & autoTest;
    cmd.encode     = start & encodeSel;
    cmd.doubleCase = start & doubleCase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= start;
  end

  assign done = doneQ;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) start |=> done);
  // R9
  done_only_chk: assert property (@(posedge clk) disable iff (!rstN) !start |=> !done);

endmodule

// File: rtl/secded_dp.sv
module secded_dp
  import secded_pkg::*;
#(
  parameter logic [DATA_W-1:0] TEST_DATA   = 64'h5A3C_96E1_0F7B_C248,
  parameter int                TEST_FLIP_A = 37,
  parameter int                TEST_FLIP_B = 50
) (
  input  logic            clk,
  input  logic            rstN,
  input  codecCmd_t       cmd,
  input  logic [CW_W-1:0] inBytes,
  output logic [CW_W-1:0] outBytes,
  output logic            secFlag,
  output logic            dedFlag
);

  localparam logic [CW_W-1:0] ONE_HOT = {{(CW_W-1){1'b0}}, 1'b1};
  localparam logic [CW_W-1:0] TEST_CW = encodeWord(TEST_DATA);
  localparam logic [CW_W-1:0] MASK_A  = ONE_HOT << TEST_FLIP_A;
  localparam logic [CW_W-1:0] MASK_B  = ONE_HOT << TEST_FLIP_B;

  logic [DATA_W-1:0] encIn;
  logic [CW_W-1:0]   encOut;
  logic [CW_W-1:0]   decIn;
  logic [DATA_W-1:0] decData;
  logic              decSec;
  logic              decDed;
  logic [CW_W-1:0]   resultWord;
  logic              resultSec;
  logic              resultDed;
  logic [CW_W-1:0]   outQ;
  logic              secQ;
  logic              dedQ;

  always_comb begin
    encIn = cmd.useVector ? TEST_DATA : inBytes[DATA_W-1:0];
    if (cmd.useVector) decIn = cmd.doubleCase ? (TEST_CW ^ MASK_A ^ MASK_B) : (TEST_CW ^ MASK_A);
    else               decIn = inBytes;
  end

  secded_enc u_enc (.dataIn(encIn), .codeOut(encOut));

  secded_dec u_dec (.codeIn(decIn), .dataOut(decData), .secHit(decSec), .dedHit(decDed));

  always_comb begin
    resultWord = cmd.encode ? encOut : {{(CW_W-DATA_W){1'b0}}, decData};
    resultSec  = cmd.encode ? 1'b0 : decSec;
    resultDed  = cmd.encode ? 1'b0 : decDed;
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            outQ[ln*LANE_W +: LANE_W] <= '0;
      else if (cmd.capture) outQ[ln*LANE_W +: LANE_W] <= resultWord[ln*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secQ <= 1'b0;
      dedQ <= 1'b0;
    end else if (cmd.capture) begin
      secQ <= resultSec;
      dedQ <= resultDed;
    end
  end

  assign outBytes = outQ;
  assign secFlag  = secQ;
  assign dedFlag  = dedQ;

  // R7
  ded_zero_chk: assert property (@(posedge clk) disable iff (!rstN) dedFlag |-> outBytes == '0);
  // R5
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(secFlag && dedFlag));
  // R11
  enc_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.capture && cmd.encode) |=> (!secFlag && !dedFlag));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.capture |=> ($stable(outBytes) && $stable(secFlag) && $stable(dedFlag)));
  // R3
  lane8_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.capture && !cmd.encode) |=> outBytes[CW_W-1:DATA_W] == '0);

endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter logic [63:0] TEST_DATA   = 64'h5A3C_96E1_0F7B_C248,
  parameter int          TEST_FLIP_A = 37,
  parameter int          TEST_FLIP_B = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        autoTest,
  input  logic        doubleCase,
  input  logic        encodeSel,
  input  logic [71:0] inBytes,
  output logic [71:0] outBytes,
  output logic        secFlag,
  output logic        dedFlag,
  output logic        done
);

  codecCmd_t cmd;

  secded_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .autoTest(autoTest),
    .doubleCase(doubleCase), .encodeSel(encodeSel), .cmd(cmd), .done(done)
  );

  secded_dp #(
    .TEST_DATA(TEST_DATA), .TEST_FLIP_A(TEST_FLIP_A), .TEST_FLIP_B(TEST_FLIP_B)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .inBytes(inBytes),
    .outBytes(outBytes), .secFlag(secFlag), .dedFlag(dedFlag)
  );

endmodule

// File: tb/secded_codec_tb.sv
`timescale 1ns/1ps
module secded_codec_tb;

  localparam logic [63:0] T_DATA = 64'hC0DE_1234_FACE_0789;
  localparam int          T_FA   = 12;
  localparam int          T_FB   = 66;

  typedef struct packed {
    logic        isEnc;
    logic [1:0]  kind;
    logic [63:0] data;
    logic [71:0] flips;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 64'h0000_0000_0000_0000, 72'h0},
    '{1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 72'h0},
    '{1'b1, 2'd0, 64'h0123_4567_89AB_CDEF, 72'h0},
    '{1'b1, 2'd0, 64'h8000_0000_0000_0001, 72'h0},
    '{1'b0, 2'd0, 64'hDEAD_BEEF_0BAD_F00D, 72'h0},
    '{1'b0, 2'd1, 64'hA5A5_5A5A_A5A5_5A5A, 72'h8},
    '{1'b0, 2'd1, 64'h1357_9BDF_2468_ACE0, 72'h80_0000_0000_0000_0000},
    '{1'b0, 2'd1, 64'hFEDC_BA98_7654_3210, 72'h01_0000_0000_0000_0000},
    '{1'b0, 2'd1, 64'h0F0F_0F0F_F0F0_F0F0, 72'h1},
    '{1'b0, 2'd2, 64'h3333_CCCC_5555_AAAA, 72'h40_0000_0000_0000_0020},
    '{1'b0, 2'd2, 64'h7777_1111_8888_EEEE, 72'h02_0000_0000_0000_0101},
    '{1'b0, 2'd2, 64'h0000_FFFF_0000_FFFF, 72'h6}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        autoTest = 1'b0;
  logic        doubleCase = 1'b0;
  logic        encodeSel = 1'b0;
  logic [71:0] inBytes = '0;
  logic [71:0] outBytes;
  logic        secFlag;
  logic        dedFlag;
  logic        done;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  secded_codec #(.TEST_DATA(T_DATA), .TEST_FLIP_A(T_FA), .TEST_FLIP_B(T_FB)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .autoTest(autoTest), .doubleCase(doubleCase),
    .encodeSel(encodeSel), .inBytes(inBytes), .outBytes(outBytes),
    .secFlag(secFlag), .dedFlag(dedFlag), .done(done)
  );

  function automatic int dataPos(input int j);
    if (j == 0)       return 3;
    else if (j <= 3)  return j + 4;
    else if (j <= 10) return j + 5;
    else if (j <= 25) return j + 6;
    else if (j <= 56) return j + 7;
    else              return j + 8;
  endfunction

  function automatic logic [71:0] refEncode(input logic [63:0] d);
    logic [71:0] w;
    logic [6:0]  chk;
    int pos;
    w = '0;
    chk = '0;
    for (int j = 0; j < 64; j++) begin
      pos = dataPos(j);
      w[pos] = d[j];
      for (int k = 0; k < 7; k++) if (pos[k]) chk[k] ^= d[j];
    end
    for (int k = 0; k < 7; k++) w[1 << k] = chk[k];
    w[0] = ^w;
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(input bit enc, input bit aut, input bit dbl, input logic [71:0] din);
    @(negedge clk);
    encodeSel = enc; autoTest = aut; doubleCase = dbl; inBytes = din; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expectResult(input string tag, input logic [71:0] expOut, input bit expSec, input bit expDed);
    check(outBytes === expOut, tag, outBytes, expOut);
    check({secFlag, dedFlag} === {expSec, expDed}, {tag, " flags"},
          {70'b0, secFlag, dedFlag}, {70'b0, expSec, expDed});
    check(done === 1'b1, {tag, " done R9"}, {71'b0, done}, 72'h1);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [71:0] cw;
    logic [71:0] held;
    repeat (3) @(negedge clk);
    // R14 reset state
    check(outBytes === '0, "R14 outBytes", outBytes, '0);
    check({secFlag, dedFlag, done} === 3'b000, "R14 flags", {69'b0, secFlag, dedFlag, done}, '0);
    rstN = 1'b1;
    @(negedge clk);

    // vector table: R2 encode, R4 clean, R5/R6 single, R7/R8 double
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isEnc) begin
        runOp(1'b1, 1'b0, 1'b0, {8'hA5, VECS[i].data});
        expectResult($sformatf("R2 enc vec %0d", i), refEncode(VECS[i].data), 1'b0, 1'b0);
      end else begin
        cw = refEncode(VECS[i].data) ^ VECS[i].flips;
        runOp(1'b0, 1'b0, 1'b0, cw);
        case (VECS[i].kind)
          2'd0: expectResult($sformatf("R4 clean vec %0d", i), {8'h0, VECS[i].data}, 1'b0, 1'b0);
          2'd1: expectResult($sformatf("%s vec %0d", (VECS[i].flips == 72'h1) ? "R6" : "R5", i),
                             {8'h0, VECS[i].data}, 1'b1, 1'b0);
          default: expectResult($sformatf("%s vec %0d", ($countones(VECS[i].flips) == 3) ? "R8" : "R7", i),
                                '0, 1'b0, 1'b1);
        endcase
      end
    end

    // R5 every single position of one word
    for (int p = 0; p < 72; p++) begin
      cw = refEncode(64'h9E37_79B9_7F4A_7C15);
      cw[p] = ~cw[p];
      runOp(1'b0, 1'b0, 1'b0, cw);
      check(outBytes === {8'h0, 64'h9E37_79B9_7F4A_7C15} && secFlag && !dedFlag,
            $sformatf("R5 flip pos %0d", p), outBytes, {8'h0, 64'h9E37_79B9_7F4A_7C15});
    end

    // R1 data placement
    runOp(1'b1, 1'b0, 1'b0, 72'h1);
    check(outBytes[3] === 1'b1, "R1 d0 at 3", outBytes, refEncode(64'h1));
    runOp(1'b1, 1'b0, 1'b0, {8'h0, 64'h1 << 26});
    check(outBytes[33] === 1'b1, "R1 d26 at 33", outBytes, refEncode(64'h1 << 26));
    runOp(1'b1, 1'b0, 1'b0, {8'h0, 64'h1 << 63});
    check(outBytes[71] === 1'b1 && outBytes[64] === 1'b1, "R1 d63 at 71", outBytes, refEncode(64'h1 << 63));

    // R3 lane 8 ignored by encoder, zero on decode
    runOp(1'b1, 1'b0, 1'b0, {8'hFF, 64'h0123_4567_89AB_CDEF});
    check(outBytes === refEncode(64'h0123_4567_89AB_CDEF), "R3 enc lane8", outBytes, refEncode(64'h0123_4567_89AB_CDEF));
    runOp(1'b0, 1'b0, 1'b0, refEncode(64'hFFFF_FFFF_FFFF_FFFF));
    check(outBytes[71:64] === 8'h00, "R3 dec lane8", outBytes, {8'h0, 64'hFFFF_FFFF_FFFF_FFFF});

    // R9 done falls after one cycle
    @(negedge clk);
    check(done === 1'b0, "R9 done pulse", {71'b0, done}, '0);

    // R10 inputs ignored without start
    held = outBytes;
    encodeSel = 1'b1; autoTest = 1'b1; doubleCase = 1'b1; inBytes = 72'hFF_1234_5678_9ABC_DEF0;
    repeat (3) @(negedge clk);
    check(outBytes === held && !secFlag && !dedFlag && !done, "R10 hold", outBytes, held);

    // R11 self-test encoder
    runOp(1'b1, 1'b1, 1'b0, 72'h0);
    expectResult("R11 auto enc sec", refEncode(T_DATA), 1'b0, 1'b0);
    runOp(1'b1, 1'b1, 1'b1, 72'hFF_FFFF_FFFF_FFFF_FFFF);
    expectResult("R11 auto enc ded", refEncode(T_DATA), 1'b0, 1'b0);

    // R12 self-test decoder single error
    runOp(1'b0, 1'b1, 1'b0, 72'h0);
    expectResult("R12 auto dec sec", {8'h0, T_DATA}, 1'b1, 1'b0);

    // R13 self-test decoder double error
    runOp(1'b0, 1'b1, 1'b1, refEncode(64'h1111));
    expectResult("R13 auto dec ded", '0, 1'b0, 1'b1);

    // R14 reset mid-run clears outputs
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(outBytes === '0 && !dedFlag && !secFlag && !done, "R14 re-reset", outBytes, '0);

    finishRun();
  end

endmodule